// File: doc/BRIEF.md
# Configuration memory burst loader

This block walks a byte image held in a serial configuration memory and turns it into 32-bit writes on an internal register bus. It reads the image one byte at a time through a request/valid port. The image opens with a validity marker and a count of bursts. Each burst has a two-byte header holding a word address and a word count, followed by that many data words.

Every register write is held back while either of two external busy lines is high. A size strap sets the highest byte address that may be read. A read past that address stops the load and raises a sticky overflow flag. A start pulse, given after reset or as a reload, launches a load. Busy status drops when the last burst has been written, when the marker is wrong, or when the limit is hit.

Top module: `cfg_burst_loader`

## Requirements
- R1: The byte at memory address 0 must equal A5h. Any other value ends the load with no register write: `busy_o` goes low and `done_o` goes high.
- R2: The byte at address 1 is the number of bursts to process. A value of 0 ends the load with no writes.
- R3: Each burst header is two bytes. The first byte is an 8-bit word address, and the write byte address `wr_addr_o` is that value with two zero bits appended below it. The second byte is a word count. A count of 0 issues no write for that burst and moves on to the next header.
- R4: Each data word is four bytes taken most significant first. The first byte becomes `wr_data_o[31:24]` and the last byte becomes `wr_data_o[7:0]`.
- R5: Within a burst the word address rises by one (4 bytes) after each write. It wraps within the 8-bit field, so the write after 3FCh goes to 000h.
- R6: `wr_en_o` is high only while both `csr_busy_i` and `mgmt_busy_i` are low. A pending write waits, without loss, for as long as either line stays high.
- R7: The readable limit is 2^(7+`size_sel_i`)−1 bytes, clamped to the memory address range. A read needed beyond the limit stops the load: `ovf_o` goes high and stays high until the next start, `busy_o` goes low, `done_o` goes high, and no further write is issued.
- R8: A `start_i` pulse restarts reading at byte 0. In the next cycle `busy_o` is 1 and both `done_o` and `ovf_o` are 0.
- R9: After the last word of the last burst is written, `busy_o` goes low and `done_o` goes high. `busy_o` and `done_o` are never high together.
- R10: After reset `busy_o`, `done_o`, `ovf_o`, `mem_req_o` and `wr_en_o` are all 0.
- R11: Bytes are requested at strictly rising addresses from 0, one request at a time. Each request holds `mem_req_o` and `mem_addr_o` steady until the cycle in which `mem_vld_i` is high, and then drops for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start or reload pulse |
| size_sel_i | input | SEL_W | Memory size strap |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | MEM_AW | Byte address of the request |
| mem_vld_i | input | 1 | Requested byte is on `mem_data_i` |
| mem_data_i | input | 8 | Byte read from memory |
| csr_busy_i | input | 1 | Switch register interface busy |
| mgmt_busy_i | input | 1 | PHY management interface busy |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 10 | Register byte address |
| wr_data_o | output | 32 | Register write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished |
| ovf_o | output | 1 | Sticky address-limit overflow |

## Verification
The status outputs follow a start pulse by one register stage, so the bench samples them on the falling edge right after the edge that captured the start. A byte is used one cycle after the edge on which `mem_vld_i` was high. The memory model responds at falling edges, with a latency of zero to two cycles that changes with the address, so that late responses are also exercised.

`wr_en_o` is a combinational result of the write-pending state and the two busy inputs. The bench therefore changes the busy inputs just after a rising edge and logs writes on falling edges. This keeps a write from being missed or counted twice. Final status and the write log are compared only once `done_o` has been seen high, and each wait is bounded.

// File: rtl/cbl_pkg.sv
// Shared definitions for the configuration burst loader.
// Assumes: one byte per memory read, 32-bit register words.
package cbl_pkg;
    localparam logic [7:0] MARKER_BYTE = 8'hA5;
    localparam int BYTE_W    = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W    = BYTE_W * WORD_BYTES;
    localparam int DWA_W     = 8;            // word address field in header
    localparam int CNT_W     = 8;            // word count field in header
    localparam int RADDR_W   = DWA_W + 2;    // register byte address

    typedef enum logic [2:0] {
        P_IDLE, P_MARK, P_NBUR, P_HDRH, P_HDRL, P_DATA, P_WRITE, P_DONE
    } pstate_t;
endpackage

// File: rtl/cbl_fetch.sv
// Byte fetcher: keeps the memory byte pointer and issues one read request at a time.
// Before each request it compares the pointer with the limit chosen by the size strap
// and pulses ovf_o instead of reading when the pointer is past it.
// Assumes: the memory answers each request with exactly one mem_vld_i cycle.
module cbl_fetch #(
    parameter int MEM_AW       = 16,
    parameter int SEL_W        = 3,
    parameter int CAP_LOG2_MIN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              want_i,
    input  logic [SEL_W-1:0]  size_sel_i,
    output logic              mem_req_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic              mem_vld_i,
    input  logic [7:0]        mem_data_i,
    output logic              rdy_o,
    output logic [7:0]        byte_o,
    output logic              ovf_o
);
    localparam int LG_W  = 8;
    localparam int PTR_W = MEM_AW + 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] limit;
    logic [LG_W-1:0]  lg;
    logic             pend_q;

    // Derive the last readable byte address from the size strap.
    always_comb begin
        lg = LG_W'(CAP_LOG2_MIN) + LG_W'(size_sel_i);
        if (lg >= LG_W'(MEM_AW))
            limit = {1'b0, {MEM_AW{1'b1}}};
        else
            limit = (PTR_W'(1) << lg) - PTR_W'(1);
    end

    // Issue requests, capture returned bytes and flag limit overruns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            pend_q <= 1'b0;
            rdy_o  <= 1'b0;
            ovf_o  <= 1'b0;
            byte_o <= '0;
        end else begin
            rdy_o <= 1'b0;
            ovf_o <= 1'b0;
            if (restart_i) begin
                ptr_q  <= '0;
                pend_q <= 1'b0;
            end else if (pend_q) begin
                if (mem_vld_i) begin
                    byte_o <= mem_data_i;
                    rdy_o  <= 1'b1;
                    ptr_q  <= ptr_q + PTR_W'(1);
                    pend_q <= 1'b0;
                end
            end else if (want_i && !rdy_o && !ovf_o) begin
                if (ptr_q > limit)
                    ovf_o <= 1'b1;
                else
                    pend_q <= 1'b1;
            end
        end
    end

    assign mem_req_o  = pend_q;
    assign mem_addr_o = ptr_q[MEM_AW-1:0];
endmodule

// File: rtl/cbl_parser.sv
// Burst list parser: checks the marker, reads the burst count, decodes headers,
// assembles words most significant byte first and presents one write at a time.
// Assumes: rdy_i pulses for one cycle per byte; wr_ack_i pulses when a write is taken.
module cbl_parser
    import cbl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               rdy_i,
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic               ovf_i,
    output logic               want_o,
    output logic               wr_req_o,
    output logic [RADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0]  wr_data_o,
    input  logic               wr_ack_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               ovf_o
);
    pstate_t            state_q;
    logic [7:0]         nb_left_q;
    logic [CNT_W-1:0]   dw_left_q;
    logic [DWA_W-1:0]   dw_addr_q;
    logic [WORD_W-1:0]  word_q;
    logic [1:0]         bidx_q;

    // Request bytes in every state that consumes one.
    always_comb begin
        unique case (state_q)
            P_MARK, P_NBUR, P_HDRH, P_HDRL, P_DATA: want_o = 1'b1;
            default:                                want_o = 1'b0;
        endcase
    end

    assign wr_req_o  = (state_q == P_WRITE);
    assign wr_addr_o = {dw_addr_q, 2'b00};
    assign wr_data_o = word_q;

    // Sequence through marker, count, headers, data and writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= P_IDLE;
            nb_left_q <= '0;
            dw_left_q <= '0;
            dw_addr_q <= '0;
            word_q    <= '0;
            bidx_q    <= '0;
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            ovf_o     <= 1'b0;
        end else if (start_i) begin
            state_q <= P_MARK;
            busy_o  <= 1'b1;
            done_o  <= 1'b0;
            ovf_o   <= 1'b0;
        end else if (ovf_i && want_o) begin
            state_q <= P_DONE;
            ovf_o   <= 1'b1;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
        end else begin
            unique case (state_q)
                P_MARK: if (rdy_i) begin
                    if (byte_i == MARKER_BYTE) begin
                        state_q <= P_NBUR;
                    end else begin
                        state_q <= P_DONE;
                        busy_o  <= 1'b0;
                        done_o  <= 1'b1;
                    end
                end
                P_NBUR: if (rdy_i) begin
                    nb_left_q <= byte_i;
                    if (byte_i == '0) begin
                        state_q <= P_DONE;
                        busy_o  <= 1'b0;
                        done_o  <= 1'b1;
                    end else begin
                        state_q <= P_HDRH;
                    end
                end
                P_HDRH: if (rdy_i) begin
                    dw_addr_q <= byte_i;
                    state_q   <= P_HDRL;
                end
                P_HDRL: if (rdy_i) begin
                    dw_left_q <= byte_i;
                    bidx_q    <= '0;
                    if (byte_i != '0) begin
                        state_q <= P_DATA;
                    end else if (nb_left_q > 8'd1) begin
                        nb_left_q <= nb_left_q - 8'd1;
                        state_q   <= P_HDRH;
                    end else begin
                        state_q <= P_DONE;
                        busy_o  <= 1'b0;
                        done_o  <= 1'b1;
                    end
                end
                P_DATA: if (rdy_i) begin
                    word_q <= {word_q[WORD_W-BYTE_W-1:0], byte_i};
                    bidx_q <= bidx_q + 2'd1;
                    if (bidx_q == 2'd3)
                        state_q <= P_WRITE;
                end
                P_WRITE: if (wr_ack_i) begin
                    dw_addr_q <= dw_addr_q + DWA_W'(1);
                    if (dw_left_q > CNT_W'(1)) begin
                        dw_left_q <= dw_left_q - CNT_W'(1);
                        state_q   <= P_DATA;
                    end else if (nb_left_q > 8'd1) begin
                        nb_left_q <= nb_left_q - 8'd1;
                        state_q   <= P_HDRH;
                    end else begin
                        state_q <= P_DONE;
                        busy_o  <= 1'b0;
                        done_o  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cbl_wgate.sv
// Write gate: passes a pending write to the register bus only while every
// busy line is low; the parser holds the write until it is accepted.
// Assumes: busy lines are synchronous to clk.
module cbl_wgate #(
    parameter int NBUSY = 2
) (
    input  logic             wr_req_i,
    input  logic [NBUSY-1:0] busy_i,
    output logic             wr_en_o,
    output logic             wr_ack_o
);
    // Grant the write when no interface reports busy.
    always_comb begin
        wr_en_o  = wr_req_i && (busy_i == '0);
        wr_ack_o = wr_en_o;
    end
endmodule

// File: rtl/cfg_burst_loader.sv
// Top level of the configuration burst loader: byte fetcher, burst list parser
// and busy-gated write stage.
// Assumes: start_i is a single-cycle pulse; memory answers every request.
module cfg_burst_loader
    import cbl_pkg::*;
#(
    parameter int MEM_AW       = 16,
    parameter int SEL_W        = 3,
    parameter int CAP_LOG2_MIN = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [SEL_W-1:0]   size_sel_i,
    output logic               mem_req_o,
    output logic [MEM_AW-1:0]  mem_addr_o,
    input  logic               mem_vld_i,
    input  logic [7:0]         mem_data_i,
    input  logic               csr_busy_i,
    input  logic               mgmt_busy_i,
    output logic               wr_en_o,
    output logic [9:0]         wr_addr_o,
    output logic [31:0]        wr_data_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               ovf_o
);
    logic              want, rdy, fovf, wr_req, wr_ack;
    logic [BYTE_W-1:0] byte_v;

    cbl_fetch #(
        .MEM_AW(MEM_AW), .SEL_W(SEL_W), .CAP_LOG2_MIN(CAP_LOG2_MIN)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .restart_i(start_i), .want_i(want),
        .size_sel_i(size_sel_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_vld_i(mem_vld_i), .mem_data_i(mem_data_i),
        .rdy_o(rdy), .byte_o(byte_v), .ovf_o(fovf)
    );

    cbl_parser u_parser (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rdy_i(rdy), .byte_i(byte_v),
        .ovf_i(fovf), .want_o(want), .wr_req_o(wr_req), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .wr_ack_i(wr_ack), .busy_o(busy_o),
        .done_o(done_o), .ovf_o(ovf_o)
    );

    cbl_wgate #(.NBUSY(2)) u_wgate (
        .wr_req_i(wr_req), .busy_i({csr_busy_i, mgmt_busy_i}),
        .wr_en_o(wr_en_o), .wr_ack_o(wr_ack)
    );
endmodule

// File: rtl/cfg_burst_loader_chk.sv
// Protocol checker for the configuration burst loader, bound to the top module.
module cfg_burst_loader_chk #(
    parameter int MEM_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              csr_busy_i,
    input logic              mgmt_busy_i,
    input logic              mem_req_o,
    input logic              mem_vld_i,
    input logic [MEM_AW-1:0] mem_addr_o,
    input logic              wr_en_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              ovf_o
);
    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (!csr_busy_i && !mgmt_busy_i));

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_idle_nowr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_en_o);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !start_i) |=> ovf_o);

    assert_ovf_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !start_i) |=> !mem_req_o);

    assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !done_o && !ovf_o));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_vld_i && !start_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_req_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_vld_i) |=> !mem_req_o);
endmodule

bind cfg_burst_loader cfg_burst_loader_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .csr_busy_i(csr_busy_i),
    .mgmt_busy_i(mgmt_busy_i), .mem_req_o(mem_req_o), .mem_vld_i(mem_vld_i),
    .mem_addr_o(mem_addr_o), .wr_en_o(wr_en_o), .busy_o(busy_o),
    .done_o(done_o), .ovf_o(ovf_o)
);

// File: tb/tb_cfg_burst_loader.sv
`timescale 1ns/1ps
module tb_cfg_burst_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  size_sel_i = 3'd3;
    logic        mem_req_o;
    logic [15:0] mem_addr_o;
    logic        mem_vld_i = 1'b0;
    logic [7:0]  mem_data_i = 8'h00;
    logic        csr_busy_i = 1'b0;
    logic        mgmt_busy_i = 1'b0;
    logic        wr_en_o;
    logic [9:0]  wr_addr_o;
    logic [31:0] wr_data_o;
    logic        busy_o, done_o, ovf_o;

    cfg_burst_loader dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0]  mem [1024];
    int          lat = 0;
    int          next_addr = 0;
    int          seq_err = 0;
    logic [9:0]  log_a [256];
    logic [31:0] log_d [256];
    int          log_n = 0;
    logic [9:0]  exp_a [256];
    logic [31:0] exp_d [256];
    int          exp_n = 0;
    bit          exp_ov = 0;

    // Scenario table: marker, bursts, first word addr, first count, size strap, writes, overflow
    localparam logic [43:0] TBL [8] = '{
        {8'hA5, 8'd1, 8'h10, 8'd1,  3'd3, 8'd1,  1'b0},
        {8'hA5, 8'd3, 8'h10, 8'd1,  3'd3, 8'd6,  1'b0},
        {8'hA5, 8'd1, 8'hFF, 8'd2,  3'd3, 8'd2,  1'b0},
        {8'hA5, 8'd2, 8'h40, 8'd0,  3'd3, 8'd1,  1'b0},
        {8'hA5, 8'd0, 8'h10, 8'd1,  3'd3, 8'd0,  1'b0},
        {8'h5A, 8'd2, 8'h10, 8'd1,  3'd3, 8'd0,  1'b0},
        {8'hA5, 8'd1, 8'h20, 8'd40, 3'd0, 8'd31, 1'b1},
        {8'hA5, 8'd2, 8'hF0, 8'd3,  3'd1, 8'd7,  1'b0}
    };

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model: answers requests after 0..2 cycles, checks address order (R11)
    always @(negedge clk) begin
        if (mem_vld_i) begin
            mem_vld_i = 1'b0;
        end else if (mem_req_o) begin
            if (lat == 0) begin
                mem_vld_i  = 1'b1;
                mem_data_i = mem[mem_addr_o[9:0]];
                if (int'(mem_addr_o) != next_addr) seq_err++;
                next_addr++;
                lat = int'(mem_addr_o) % 3;
            end else begin
                lat--;
            end
        end
    end

    // Register write log
    always @(negedge clk) begin
        if (wr_en_o && log_n < 256) begin
            log_a[log_n] = wr_addr_o;
            log_d[log_n] = wr_data_o;
            log_n++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic build(logic [7:0] mk, logic [7:0] nb, logic [7:0] a0, logic [7:0] c0);
        int p;
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 11) & 255);
        mem[0] = mk; mem[1] = nb;
        p = 2;
        for (int b = 0; b < int'(nb); b++) begin
            mem[p % 1024]       = 8'(int'(a0) + 16 * b);
            mem[(p + 1) % 1024] = 8'(int'(c0) + b);
            p += 2 + 4 * (int'(c0) + b);
        end
    endtask

    function automatic int rdm(int p, int lim);
        return (p > lim) ? -1 : int'(mem[p % 1024]);
    endfunction

    // Expected writes computed from the requirements
    task automatic model(int sel);
        int lim, p, v, nb, a, c;
        logic [31:0] w;
        lim = (1 << (7 + sel)) - 1;
        exp_n = 0; exp_ov = 0; p = 0;
        v = rdm(p++, lim); if (v < 0) begin exp_ov = 1; return; end
        if (v != 8'hA5) return;
        v = rdm(p++, lim); if (v < 0) begin exp_ov = 1; return; end
        nb = v;
        for (int b = 0; b < nb; b++) begin
            a = rdm(p++, lim); if (a < 0) begin exp_ov = 1; return; end
            c = rdm(p++, lim); if (c < 0) begin exp_ov = 1; return; end
            for (int d = 0; d < c; d++) begin
                for (int k = 0; k < 4; k++) begin
                    v = rdm(p++, lim); if (v < 0) begin exp_ov = 1; return; end
                    w = {w[23:0], 8'(v)};
                end
                exp_a[exp_n] = {8'(a + d), 2'b00};
                exp_d[exp_n] = w;
                exp_n++;
            end
        end
    endtask

    task automatic pulse_start();
        log_n = 0; next_addr = 0;
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
        chk(done_o == 1'b0 && ovf_o == 1'b0, "R8", "done/ovf cleared", {done_o, ovf_o}, 0);
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done_o && t < 20000) begin @(negedge clk); t++; end
        chk(done_o == 1'b1, "R9", "done reached", done_o, 1);
        chk(busy_o == 1'b0, "R9", "busy cleared", busy_o, 0);
    endtask

    task automatic compare(int n_tab, bit ov_tab, string tag);
        chk(log_n == n_tab, "R1/R2/R3", {tag, " write count"}, log_n, n_tab);
        chk(exp_n == n_tab, "R3", {tag, " model count"}, exp_n, n_tab);
        chk(ovf_o == ov_tab, "R7", {tag, " overflow flag"}, ovf_o, ov_tab);
        for (int i = 0; i < log_n && i < exp_n; i++) begin
            chk(log_a[i] == exp_a[i], "R5", {tag, " write address"}, log_a[i], exp_a[i]);
            chk(log_d[i] == exp_d[i], "R4", {tag, " write data"}, log_d[i], exp_d[i]);
        end
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({busy_o, done_o, ovf_o, mem_req_o, wr_en_o} == 5'b0, "R10", "reset outputs",
            {busy_o, done_o, ovf_o, mem_req_o, wr_en_o}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy_o, done_o, mem_req_o} == 3'b0, "R10", "idle after reset",
            {busy_o, done_o, mem_req_o}, 0);

        // Table walk
        for (int v = 0; v < 8; v++) begin
            logic [43:0] e;
            e = TBL[v];
            size_sel_i = e[11:9];
            build(e[43:36], e[35:28], e[27:20], e[19:12]);
            model(int'(e[11:9]));
            pulse_start();
            wait_done();
            compare(int'(e[8:1]), e[0], $sformatf("vec%0d", v));
        end

        // R6: writes held while either busy line is high
        size_sel_i = 3'd3;
        build(8'hA5, 8'd3, 8'h10, 8'd1);
        model(3);
        @(posedge clk); #1 csr_busy_i = 1'b1;
        pulse_start();
        repeat (200) @(negedge clk);
        chk(log_n == 0, "R6", "no write while csr busy", log_n, 0);
        chk(busy_o == 1'b1, "R6", "still busy while held", busy_o, 1);
        @(posedge clk); #1 begin csr_busy_i = 1'b0; mgmt_busy_i = 1'b1; end
        repeat (100) @(negedge clk);
        chk(log_n == 0, "R6", "no write while mgmt busy", log_n, 0);
        @(posedge clk); #1 mgmt_busy_i = 1'b0;
        wait_done();
        compare(6, 1'b0, "held");

        // R7 then R8: reload after overflow clears the flag
        size_sel_i = 3'd0;
        build(8'hA5, 8'd1, 8'h20, 8'd40);
        model(0);
        pulse_start();
        wait_done();
        chk(ovf_o == 1'b1, "R7", "overflow set", ovf_o, 1);
        repeat (20) @(negedge clk);
        chk(ovf_o == 1'b1 && mem_req_o == 1'b0, "R7", "overflow sticky, reads stopped",
            {ovf_o, mem_req_o}, 2);
        size_sel_i = 3'd3;
        build(8'hA5, 8'd1, 8'h10, 8'd1);
        model(3);
        pulse_start();
        wait_done();
        compare(1, 1'b0, "reload");

        // R11: request order
        chk(seq_err == 0, "R11", "sequential byte addresses", seq_err, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule